// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Control

This block compares two divided-down pulse trains inside a frequency synthesiser loop: the output of the reference divider and the output of the feedback (RF) divider. It sets an up flag on a rising edge of one input and a down flag on a rising edge of the other. The first clock in which both flags are high clears them both, so even a zero phase error gives a one-cycle pulse on each and there is no dead band. The gated up/down flags drive a charge pump outside this block.

A lock detector measures, in each period of the up-side input, how many clocks exactly one of the two flags was high. Lock is declared after a programmable run of consecutive good periods. It is withdrawn after a run one third as long of consecutive bad periods.

A 2-bit state input has three jobs:
- it turns the registered monitor copies of both divider pulses on or off;
- it can switch the correction outputs off permanently;
- it can hand control to an external detector once lock is flagged.

A sense input swaps the two divider signals at the detector and swaps the two monitor outputs with them. This reverses the correction direction. A charge-pump enable from the programming logic gates the correction outputs.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: When the up-side input rises d clocks (d >= 0) before the other input, up_o is high for d+1 clocks and dn_o for 1 clock. With the roles reversed, dn_o is high for d+1 clocks and up_o for 1 clock. The two outputs overlap in exactly one clock, and both clear on the clock after the overlap.
- R2: With sense_i = 0 the up-side input is ref_pulse_i. With sense_i = 1 it is fb_pulse_i.
- R3: mon_ref_o is a one-clock-delayed copy of ref_pulse_i when sense_i = 0, and of fb_pulse_i when sense_i = 1. mon_fb_o carries the other input.
- R4: With state_i = 2'b00, mon_ref_o and mon_fb_o stay low. With any other state they carry the copies of R3.
- R5: With state_i = 2'b11, up_o and dn_o stay low. With 2'b00 or 2'b01 they follow R1.
- R6: With state_i = 2'b10, up_o and dn_o follow R1 while lock_o is low and stay low while lock_o is high.
- R7: While cp_en_i is low, up_o and dn_o stay low. The lock detector keeps running.
- R8: A period is good when its error count is at most ERR_THR (default 2). The error count is the number of clocks, between consecutive up-side rising edges, in which exactly one of the internal up/down flags is high. The first up-side edge after reset only opens a window. lock_o rises at the up-side edge that ends the L-th consecutive good period, where L = lock_len_i (or 1 if lock_len_i = 0).
- R9: A period with an error count above ERR_THR restarts the good-period run, so persistent errors of ERR_THR+1 clocks never set lock_o.
- R10: While locked, lock_o falls at the edge ending the U-th consecutive bad period, where U = max(1, L/3) using integer division.
- R11: While rst_ni is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Reference divider output pulse |
| fb_pulse_i | input | 1 | Feedback divider output pulse |
| state_i | input | 2 | Detector/monitor state: 00 on/monitor off, 01 on/monitor on, 10 off after lock/monitor on, 11 off/monitor on |
| sense_i | input | 1 | Swaps detector inputs and monitor outputs |
| cp_en_i | input | 1 | Charge-pump enable; low forces up_o and dn_o low |
| lock_len_i | input | CNT_W | Good periods required for lock |
| up_o | output | 1 | Gated up correction pulse |
| dn_o | output | 1 | Gated down correction pulse |
| mon_ref_o | output | 1 | Monitor copy of the reference side |
| mon_fb_o | output | 1 | Monitor copy of the feedback side |
| lock_o | output | 1 | Lock flag |

## Verification
Errors in the internal flags show up at the ports within one input period. A flag that stays set or clears late makes the per-period width of up_o or dn_o differ from d+1 and 1. A missing clear also makes the overlap differ from one clock. A wrong swap shows as up and down widths exchanged, or as a monitor output that mismatches its delayed input on the first pulse. A corrupted good or bad counter, or a wrong threshold comparison, moves the lock_o edge to a different up-side pulse index. The bench counts pulses from reset to pin down that index exactly.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PD_ON_MON_OFF = 2'b00,
    PD_ON_MON_ON  = 2'b01,
    PD_HANDOFF    = 2'b10,
    PD_OFF        = 2'b11
  } pd_state_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic up_o,
  output logic dn_o,
  output logic a_rise_o
);
  logic a_q, b_q, up_q, dn_q;
  logic a_rise, b_rise;

  assign a_rise = a_i & ~a_q;
  assign b_rise = b_i & ~b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= 1'b0;
      b_q  <= 1'b0;
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      if (up_q && dn_q) begin
        // zero dead band: both flags live for exactly one overlap clock
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        up_q <= up_q | a_rise;
        dn_q <= dn_q | b_rise;
      end
    end
  end

  assign up_o     = up_q;
  assign dn_o     = dn_q;
  assign a_rise_o = a_rise;

  AST_ZERO_DEADBAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && dn_q) |=> (!up_q && !dn_q)); // R1
  AST_UP_FROM_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_q) |-> $past(a_rise)); // R1
endmodule

// File: rtl/lock_det.sv
module lock_det #(
  parameter int CNT_W   = 8,
  parameter int ERR_W   = 6,
  parameter int ERR_THR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic [CNT_W-1:0] lock_len_i,
  output logic             lock_o
);
  localparam logic [ERR_W-1:0] THR     = ERR_W'(ERR_THR);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [ERR_W-1:0] err_cnt;
  logic [CNT_W-1:0] good_cnt, bad_cnt;
  logic [CNT_W-1:0] lock_len, unlock_len, third;
  logic             win_vld, lock_q, judge, good, err_now;

  assign lock_len   = (lock_len_i == '0) ? CNT_W'(1) : lock_len_i;
  assign third      = lock_len / CNT_W'(3);
  assign unlock_len = (third == '0) ? CNT_W'(1) : third;
  assign err_now    = up_i ^ dn_i;
  assign judge      = win_i & win_vld;
  assign good       = (err_cnt <= THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt  <= '0;
      win_vld  <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
      lock_q   <= 1'b0;
    end else begin
      if (win_i) begin
        err_cnt <= err_now ? ERR_W'(1) : '0;
        win_vld <= 1'b1;
      end else if (err_now && err_cnt != ERR_MAX) begin
        err_cnt <= err_cnt + 1'b1;
      end
      if (judge) begin
        if (!lock_q) begin
          bad_cnt <= '0;
          if (!good) good_cnt <= '0;
          else if ({1'b0, good_cnt} + 1'b1 >= {1'b0, lock_len}) begin
            lock_q   <= 1'b1;
            good_cnt <= '0;
          end else good_cnt <= good_cnt + 1'b1;
        end else begin
          good_cnt <= '0;
          if (good) bad_cnt <= '0;
          else if ({1'b0, bad_cnt} + 1'b1 >= {1'b0, unlock_len}) begin
            lock_q  <= 1'b0;
            bad_cnt <= '0;
          end else bad_cnt <= bad_cnt + 1'b1;
        end
      end
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_AT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(judge && good)); // R8
  AST_UNLOCK_AT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(judge && (err_cnt > THR))); // R10
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
  import pfd_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int ERR_W   = 6,
  parameter int ERR_THR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_pulse_i,
  input  logic             fb_pulse_i,
  input  logic [1:0]       state_i,
  input  logic             sense_i,
  input  logic             cp_en_i,
  input  logic [CNT_W-1:0] lock_len_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             mon_ref_o,
  output logic             mon_fb_o,
  output logic             lock_o
);
  pd_state_e st;
  logic a_sig, b_sig, up_raw, dn_raw, a_rise, lock_w;
  logic det_en, mon_en, mon_ref_q, mon_fb_q;

  assign st    = pd_state_e'(state_i);
  assign a_sig = sense_i ? fb_pulse_i : ref_pulse_i;
  assign b_sig = sense_i ? ref_pulse_i : fb_pulse_i;

  pfd_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (a_sig),
    .b_i      (b_sig),
    .up_o     (up_raw),
    .dn_o     (dn_raw),
    .a_rise_o (a_rise)
  );

  lock_det #(
    .CNT_W   (CNT_W),
    .ERR_W   (ERR_W),
    .ERR_THR (ERR_THR)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_i      (a_rise),
    .up_i       (up_raw),
    .dn_i       (dn_raw),
    .lock_len_i (lock_len_i),
    .lock_o     (lock_w)
  );

  always_comb begin
    case (st)
      PD_ON_MON_OFF, PD_ON_MON_ON: det_en = 1'b1;
      PD_HANDOFF:                  det_en = ~lock_w;
      default:                     det_en = 1'b0;
    endcase
  end

  assign mon_en = (st != PD_ON_MON_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_ref_q <= 1'b0;
      mon_fb_q  <= 1'b0;
    end else begin
      mon_ref_q <= mon_en & a_sig;
      mon_fb_q  <= mon_en & b_sig;
    end
  end

  assign up_o      = up_raw & det_en & cp_en_i;
  assign dn_o      = dn_raw & det_en & cp_en_i;
  assign mon_ref_o = mon_ref_q;
  assign mon_fb_o  = mon_fb_q;
  assign lock_o    = lock_w;

  AST_MON_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == PD_ON_MON_OFF) |=> (!mon_ref_o && !mon_fb_o)); // R4
endmodule

// File: tb/pfd_lock_ctrl_test.sv
`timescale 1ns/1ps
module pfd_lock_ctrl_test;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_p = 1'b0, fb_p = 1'b0;
  logic [1:0] st = 2'b01;
  logic       sense = 1'b0, cp_en = 1'b1;
  logic [7:0] llen = 8'd6;
  logic       up_o, dn_o, mon_ref_o, mon_fb_o, lock_o;

  int k = 0, off = 0;
  int up_cnt, dn_cnt, ovl_cnt, mref_hi, mfb_hi, mon_err;
  int upside_seen, rise_at, fall_at;
  logic lock_prev;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfd_lock_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_pulse_i(ref_p), .fb_pulse_i(fb_p),
    .state_i(st), .sense_i(sense), .cp_en_i(cp_en), .lock_len_i(llen),
    .up_o(up_o), .dn_o(dn_o), .mon_ref_o(mon_ref_o), .mon_fb_o(mon_fb_o),
    .lock_o(lock_o)
  );

  // observe outputs, then drive the next pulse values
  always @(negedge clk) begin
    if (!rst_n) begin
      k = 0; ref_p = 1'b0; fb_p = 1'b0;
    end else begin
      if (up_o) up_cnt++;
      if (dn_o) dn_cnt++;
      if (up_o && dn_o) ovl_cnt++;
      if (mon_ref_o) mref_hi++;
      if (mon_fb_o) mfb_hi++;
      if (mon_ref_o !== ((st != 2'b00) && (sense ? fb_p : ref_p))) mon_err++;
      if (mon_fb_o !== ((st != 2'b00) && (sense ? ref_p : fb_p))) mon_err++;
      if (sense ? fb_p : ref_p) upside_seen++;
      if (lock_o && !lock_prev) rise_at = upside_seen;
      if (!lock_o && lock_prev) fall_at = upside_seen;
      lock_prev = lock_o;
      k = k + 1;
      ref_p = ((k % P) == 8);
      fb_p = ((k % P) == 8 + off);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_cnt();
    up_cnt = 0; dn_cnt = 0; ovl_cnt = 0; mref_hi = 0; mfb_hi = 0; mon_err = 0;
  endtask

  task automatic start(input logic [1:0] s, input logic sn, input logic ce, input int len, input int o);
    @(posedge clk); #1;
    rst_n = 1'b0; st = s; sense = sn; cp_en = ce; llen = 8'(len); off = o;
    repeat (3) @(posedge clk);
    #1;
    clear_cnt();
    upside_seen = 0; rise_at = -1; fall_at = -1; lock_prev = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic wait_per(input int n);
    repeat (n * P) @(posedge clk);
    #1;
  endtask

  task automatic wait_lock(input int maxc);
    for (int i = 0; i < maxc && !lock_o; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic width_case(input logic sn, input int o, input string req);
    int lead, eu, ed;
    start(2'b01, sn, 1'b1, 6, o);
    wait_per(2);
    clear_cnt();
    wait_per(4);
    lead = sn ? -o : o;
    eu = 4 * ((lead >= 0) ? lead + 1 : 1);
    ed = 4 * ((lead <= 0) ? -lead + 1 : 1);
    chk(up_cnt == eu, req, $sformatf("up width off=%0d sense=%0d", o, sn), up_cnt, eu);
    chk(dn_cnt == ed, req, $sformatf("dn width off=%0d sense=%0d", o, sn), dn_cnt, ed);
    chk(ovl_cnt == 4, "R1", "overlap count", ovl_cnt, 4);
    chk(mon_err == 0, "R3", "monitor copy mismatches", mon_err, 0);
  endtask

  initial begin
    // R11 reset state
    repeat (2) @(posedge clk);
    #2;
    chk({up_o, dn_o, mon_ref_o, mon_fb_o, lock_o} == 5'b0, "R11", "outputs in reset",
        {up_o, dn_o, mon_ref_o, mon_fb_o, lock_o}, 0);

    // R1 sweep over phase offsets, normal sense
    for (int o = -5; o <= 5; o++) width_case(1'b0, o, "R1");
    // R2 swapped sense
    width_case(1'b1, 4, "R2");
    width_case(1'b1, -3, "R2");
    width_case(1'b1, 0, "R2");

    // R4 monitor off in state 00, detector still active
    start(2'b00, 1'b0, 1'b1, 6, 2);
    wait_per(5);
    chk(mref_hi == 0 && mfb_hi == 0, "R4", "monitor high samples state 00", mref_hi + mfb_hi, 0);
    chk(mon_err == 0, "R4", "monitor mismatches state 00", mon_err, 0);
    chk(up_cnt > 0, "R5", "up active in state 00", up_cnt, 1);

    // R5 detector off in state 11, monitor on
    start(2'b11, 1'b0, 1'b1, 6, 3);
    wait_per(5);
    chk(up_cnt + dn_cnt == 0, "R5", "up/dn samples state 11", up_cnt + dn_cnt, 0);
    chk(mref_hi == 5 && mfb_hi == 5, "R3", "monitor pulses state 11", mref_hi + mfb_hi, 10);

    // R7 charge-pump enable low; lock still forms
    start(2'b01, 1'b0, 1'b0, 6, 0);
    wait_per(10);
    chk(up_cnt + dn_cnt == 0, "R7", "up/dn with cp_en low", up_cnt + dn_cnt, 0);
    chk(lock_o == 1'b1, "R7", "lock with cp_en low", lock_o, 1);

    // R8 lock index L+1 with L=6
    start(2'b01, 1'b0, 1'b1, 6, 0);
    wait_per(12);
    chk(rise_at == 7, "R8", "lock rise up-side pulse index L=6", rise_at, 7);
    // R8 boundary: error equal to threshold is good
    start(2'b01, 1'b0, 1'b1, 6, 2);
    wait_per(12);
    chk(rise_at == 7, "R8", "lock rise at error=THR", rise_at, 7);
    start(2'b01, 1'b0, 1'b1, 6, -2);
    wait_per(12);
    chk(rise_at == 7, "R8", "lock rise at lead error=THR", rise_at, 7);
    // R8 zero length treated as one
    start(2'b01, 1'b0, 1'b1, 0, 0);
    wait_per(5);
    chk(rise_at == 2, "R8", "lock rise with lock_len 0", rise_at, 2);

    // R9 error above threshold never locks
    start(2'b01, 1'b0, 1'b1, 6, 3);
    wait_per(14);
    chk(lock_o == 1'b0 && rise_at == -1, "R9", "lock with error THR+1", rise_at, -1);
    start(2'b01, 1'b0, 1'b1, 6, -3);
    wait_per(14);
    chk(lock_o == 1'b0 && rise_at == -1, "R9", "lock with lead error THR+1", rise_at, -1);

    // R10 unlock after L/3 bad periods
    start(2'b01, 1'b0, 1'b1, 6, 0);
    wait_lock(20 * P);
    off = 5;
    wait_per(6);
    chk(fall_at - rise_at == 2, "R10", "bad periods to unlock L=6", fall_at - rise_at, 2);
    chk(lock_o == 1'b0, "R10", "lock after bad periods", lock_o, 0);

    // R6 handoff state: active before lock, silent after
    start(2'b10, 1'b0, 1'b1, 6, 1);
    wait_per(1);
    clear_cnt();
    wait_per(3);
    chk(up_cnt == 6 && dn_cnt == 3, "R6", "up samples before lock", up_cnt, 6);
    wait_lock(20 * P);
    clear_cnt();
    wait_per(4);
    chk(lock_o == 1'b1, "R6", "lock in handoff state", lock_o, 1);
    chk(up_cnt + dn_cnt == 0, "R6", "up/dn after lock", up_cnt + dn_cnt, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule